// File: doc/BRIEF.md
# Manchester II Word Transmitter with Destination Steering

This block serialises 16-bit words for a dual-redundant serial bus. Each word is sent as a frame that opens with a sync field three bit times long. The sync is followed by the data bits, most significant first, in Manchester II coding, and the frame ends with an odd parity bit. The host side writes each word into a holding register, together with a sync-type select and a destination code. While one word is being shifted out, the next word can be written. The following frame then starts with no idle gap.

Every frame is steered to exactly one of four differential pairs: bus channel A, bus channel B, or the self-test loopback into the channel A or channel B receiver. All pairs that are not selected stay at the idle level, with both lines low. A fail-safe timer counts clocks while the transmitter is active. If the count reaches the limit, which defaults to 730 ms at 12 MHz, the frame in progress is cut off at once, the holding register is flushed and a sticky timeout flag is raised. The timer count is cleared by a valid-command pulse, by reset and by its own expiry.

Top module: `manch_tx`

## Requirements
- R1: After reset, every output line is low, `tx_active` is 0, `timeout_flag` is 0 and `load_ready` is 1.
- R2: A frame is 40 half-bit periods of HALF_CLKS clocks each (6 by default), and the first one begins on the second clock after the load is accepted. With `load_sync`=1 the positive line is high for the first three half-bits and low for the next three. With `load_sync`=0 it is the reverse. The negative line of the selected pair is always the complement of the positive line.
- R3: The data bits follow the sync, bit 15 first. A 1 is sent high then low on the positive line, and a 0 is sent low then high.
- R4: The last bit of the frame is a parity bit, coded in the same way as a data bit. It makes the count of ones across the 16 data bits and the parity bit odd.
- R5: `load_ready` is high exactly while the holding register is empty and no timeout is flagged. A word accepted during a frame is transmitted right after that frame, with no idle clock between them.
- R6: `load_dest` is captured with the word. Code 0 selects bus A, 1 selects bus B, 2 selects loopback A and 3 selects loopback B. Only the selected pair toggles, and the other three pairs stay low. In particular, both bus pairs stay low during self-test.
- R7: When no frame is being sent, all eight lines are low and `tx_active` is 0.
- R8: The timer counts every clock on which `tx_active` is 1. After TIMEOUT_CLKS such clocks without a clear, the transmitter stops: from the next clock, all lines are low and `tx_active` is 0.
- R9: A one-clock `cmd_valid` pulse sets the timer count back to zero.
- R10: On expiry, `timeout_flag` rises and stays high until reset. While it is high, `load_ready` is 0, the holding register is emptied and no frame starts.
- R11: A load presented while `load_ready` is 0 is ignored: the word already held is the one transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (12 MHz by default) |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Write strobe for the holding register |
| load_data | input | DATA_W | Word to transmit |
| load_sync | input | 1 | Sync type: 1 = high-first, 0 = low-first |
| load_dest | input | 2 | Destination code for this word |
| load_ready | output | 1 | Holding register can accept a word |
| cmd_valid | input | 1 | Valid-command pulse; clears the fail-safe timer |
| bus_a_p | output | 1 | Bus channel A, positive line |
| bus_a_n | output | 1 | Bus channel A, negative line |
| bus_b_p | output | 1 | Bus channel B, positive line |
| bus_b_n | output | 1 | Bus channel B, negative line |
| loop_a_p | output | 1 | Self-test loopback into receiver A, positive |
| loop_a_n | output | 1 | Self-test loopback into receiver A, negative |
| loop_b_p | output | 1 | Self-test loopback into receiver B, positive |
| loop_b_n | output | 1 | Self-test loopback into receiver B, negative |
| tx_active | output | 1 | A frame is being driven |
| timeout_flag | output | 1 | Sticky fail-safe expiry indicator |

## Verification
The bench keeps the default HALF_CLKS of 6, so every frame is the full 240-clock pattern that the requirements describe. It lowers TIMEOUT_CLKS from 8,760,000 to 400, which is shorter than two back-to-back frames but longer than one. With that limit, an expiry in the middle of the second word can be observed. The same limit shows that a `cmd_valid` pulse placed inside the first of two frames prevents the expiry. Both cases fit in a few hundred clocks.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
   localparam int NUM_DEST = 4;
   localparam int DEST_W   = 2;
   localparam int SYNC_HALVES = 6;   // three bit times

   typedef enum logic [DEST_W-1:0] {
      DST_BUS_A  = 2'd0,
      DST_BUS_B  = 2'd1,
      DST_LOOP_A = 2'd2,
      DST_LOOP_B = 2'd3
   } dest_e;
endpackage

// File: rtl/mtx_hold_buf.sv
module mtx_hold_buf
   import mtx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_sync,
   input  dest_e             wr_dest,
   input  logic              rd_en,
   output logic              full,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_sync,
   output dest_e             rd_dest
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("mtx_hold_buf: DATA_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full    <= 1'b0;
         rd_data <= '0;
         rd_sync <= 1'b0;
         rd_dest <= DST_BUS_A;
      end else if (flush || rd_en) begin
         full <= 1'b0;
      end else if (wr_en && !full) begin
         full    <= 1'b1;
         rd_data <= wr_data;
         rd_sync <= wr_sync;
         rd_dest <= wr_dest;
      end
   end

   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      full && !rd_en && !flush |=> full && $stable(rd_data)) else $error("held word changed"); // R11
endmodule

// File: rtl/mtx_serializer.sv
module mtx_serializer
   import mtx_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int HALF_CLKS = 6,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              word_avail,
   input  logic [DATA_W-1:0] word_data,
   input  logic              word_sync,
   input  dest_e             word_dest,
   output logic              take,
   output logic              busy,
   output logic              level,
   output dest_e             dest_q
);
   localparam int DATA_HALVES  = 2 * DATA_W;
   localparam int FRAME_HALVES = SYNC_HALVES + DATA_HALVES + 2;
   localparam int HIDX_W       = $clog2(FRAME_HALVES);
   localparam int CNT_W        = $clog2(HALF_CLKS);

   generate
      if (HALF_CLKS < 2) begin : g_bad_half
         $error("mtx_serializer: HALF_CLKS must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt;
   logic [HIDX_W-1:0] hidx;
   logic [DATA_W-1:0] word_q;
   logic              sync_q;
   logic              half_end, frame_end;

   assign half_end  = busy && (cnt == CNT_W'(HALF_CLKS - 1));
   assign frame_end = half_end && (hidx == HIDX_W'(FRAME_HALVES - 1));
   assign take      = word_avail && !abort && (!busy || frame_end);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         hidx   <= '0;
         word_q <= '0;
         sync_q <= 1'b0;
         dest_q <= DST_BUS_A;
      end else if (abort) begin
         busy <= 1'b0;
         cnt  <= '0;
         hidx <= '0;
      end else if (take) begin
         busy   <= 1'b1;
         cnt    <= '0;
         hidx   <= '0;
         word_q <= word_data;
         sync_q <= word_sync;
         dest_q <= word_dest;
      end else if (busy) begin
         if (half_end) begin
            cnt <= '0;
            if (frame_end) busy <= 1'b0;
            else           hidx <= hidx + 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // data bit selection: order chosen at elaboration
   logic [HIDX_W-1:0] data_off;
   logic [HIDX_W-1:0] bit_idx;
   logic [DATA_W-1:0] shifted;
   logic              data_bit;

   assign data_off = hidx - HIDX_W'(SYNC_HALVES);
   assign bit_idx  = data_off >> 1;

   generate
      if (MSB_FIRST) begin : g_msb_first
         assign shifted  = word_q << bit_idx;
         assign data_bit = shifted[DATA_W-1];
      end else begin : g_lsb_first
         assign shifted  = word_q >> bit_idx;
         assign data_bit = shifted[0];
      end
   endgenerate

   logic par_bit;
   assign par_bit = ~^word_q;   // odd parity over data plus parity

   always_comb begin
      if (hidx < HIDX_W'(SYNC_HALVES)) begin
         level = (hidx < HIDX_W'(SYNC_HALVES / 2)) ? sync_q : !sync_q;
      end else if (hidx < HIDX_W'(SYNC_HALVES + DATA_HALVES)) begin
         level = data_off[0] ? !data_bit : data_bit;
      end else begin
         level = (hidx == HIDX_W'(FRAME_HALVES - 2)) ? par_bit : !par_bit;
      end
   end

   AST_HALF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (cnt != '0) |-> $stable(level)) else $error("level moved inside half-bit"); // R2
   AST_MID_BIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (hidx >= HIDX_W'(SYNC_HALVES)) && hidx[0] && (cnt == '0) |-> level != $past(level))
      else $error("no mid-bit transition"); // R3
endmodule

// File: rtl/mtx_failsafe_timer.sv
module mtx_failsafe_timer #(
   parameter int LIMIT = 8760000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   output logic expire,
   output logic flag
);
   localparam int CNT_W = $clog2(LIMIT);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("mtx_failsafe_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign expire = run && !clear && (cnt == CNT_W'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else begin
         if (clear || expire) cnt <= '0;
         else if (run)        cnt <= cnt + 1'b1;
         if (expire) flag <= 1'b1;
      end
   end

   AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(LIMIT)) else $error("timer count out of range"); // R8
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt == '0) else $error("clear ignored"); // R9
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag |=> flag) else $error("timeout flag dropped"); // R10
endmodule

// File: rtl/mtx_route.sv
module mtx_route
   import mtx_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                level,
   input  dest_e               dest,
   output logic [NUM_DEST-1:0] pos,
   output logic [NUM_DEST-1:0] neg
);
   generate
      for (genvar i = 0; i < NUM_DEST; i++) begin : g_pair
         logic sel;
         assign sel    = en && (dest == DEST_W'(i));
         assign pos[i] = sel && level;
         assign neg[i] = sel && !level;
      end
   endgenerate

   AST_ONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pos | neg)) else $error("more than one pair driven"); // R6
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (pos == '0) && (neg == '0)) else $error("idle lines not low"); // R7
   AST_PAIR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> $countones(pos | neg) == 1) else $error("active pair missing"); // R6
endmodule

// File: rtl/manch_tx.sv
module manch_tx
   import mtx_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int CLK_KHZ      = 12000,
   parameter int HALF_CLKS    = CLK_KHZ / 2000,
   parameter int TIMEOUT_MS   = 730,
   parameter int TIMEOUT_CLKS = CLK_KHZ * TIMEOUT_MS,
   parameter bit MSB_FIRST    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_valid,
   input  logic [DATA_W-1:0] load_data,
   input  logic              load_sync,
   input  logic [1:0]        load_dest,
   output logic              load_ready,
   input  logic              cmd_valid,
   output logic              bus_a_p,
   output logic              bus_a_n,
   output logic              bus_b_p,
   output logic              bus_b_n,
   output logic              loop_a_p,
   output logic              loop_a_n,
   output logic              loop_b_p,
   output logic              loop_b_n,
   output logic              tx_active,
   output logic              timeout_flag
);
   logic              hold_full, hold_sync, take, busy, level, expire;
   logic [DATA_W-1:0] hold_data;
   dest_e             hold_dest, cur_dest;
   logic [NUM_DEST-1:0] pos, neg;

   assign load_ready = !hold_full && !timeout_flag;

   mtx_hold_buf #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (expire || timeout_flag),
      .wr_en   (load_valid && load_ready),
      .wr_data (load_data),
      .wr_sync (load_sync),
      .wr_dest (dest_e'(load_dest)),
      .rd_en   (take),
      .full    (hold_full),
      .rd_data (hold_data),
      .rd_sync (hold_sync),
      .rd_dest (hold_dest)
   );

   mtx_serializer #(.DATA_W(DATA_W), .HALF_CLKS(HALF_CLKS), .MSB_FIRST(MSB_FIRST)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort      (expire),
      .word_avail (hold_full && !timeout_flag),
      .word_data  (hold_data),
      .word_sync  (hold_sync),
      .word_dest  (hold_dest),
      .take       (take),
      .busy       (busy),
      .level      (level),
      .dest_q     (cur_dest)
   );

   mtx_failsafe_timer #(.LIMIT(TIMEOUT_CLKS)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy),
      .clear  (cmd_valid),
      .expire (expire),
      .flag   (timeout_flag)
   );

   mtx_route u_route (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (busy),
      .level (level),
      .dest  (cur_dest),
      .pos   (pos),
      .neg   (neg)
   );

   assign tx_active = busy;
   assign bus_a_p   = pos[DST_BUS_A];
   assign bus_a_n   = neg[DST_BUS_A];
   assign bus_b_p   = pos[DST_BUS_B];
   assign bus_b_n   = neg[DST_BUS_B];
   assign loop_a_p  = pos[DST_LOOP_A];
   assign loop_a_n  = neg[DST_LOOP_A];
   assign loop_b_p  = pos[DST_LOOP_B];
   assign loop_b_n  = neg[DST_LOOP_B];

   AST_HALT_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_flag |-> !tx_active && !load_ready) else $error("activity after timeout"); // R10
endmodule

// File: tb/manch_tx_bench.sv
`timescale 1ns/1ps
module manch_tx_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_valid = 1'b0;
   logic [15:0] load_data = '0;
   logic        load_sync = 1'b0;
   logic [1:0]  load_dest = '0;
   logic        cmd_valid = 1'b0;
   logic        load_ready, tx_active, timeout_flag;
   logic        bus_a_p, bus_a_n, bus_b_p, bus_b_n;
   logic        loop_a_p, loop_a_n, loop_b_p, loop_b_n;
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   manch_tx #(.TIMEOUT_CLKS(400)) u_manch_tx (
      .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
      .load_sync(load_sync), .load_dest(load_dest), .load_ready(load_ready),
      .cmd_valid(cmd_valid), .bus_a_p(bus_a_p), .bus_a_n(bus_a_n),
      .bus_b_p(bus_b_p), .bus_b_n(bus_b_n), .loop_a_p(loop_a_p), .loop_a_n(loop_a_n),
      .loop_b_p(loop_b_p), .loop_b_n(loop_b_n), .tx_active(tx_active),
      .timeout_flag(timeout_flag));

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // expected positive-line level at cycle c of a frame (6 clocks per half)
   function automatic logic exp_level(input logic [15:0] d, input logic s, input int c);
      int h;
      int k;
      logic p;
      h = c / 6;
      if (h < 3) return s;
      if (h < 6) return !s;
      if (h < 38) begin
         k = (h - 6) / 2;
         return (((h - 6) % 2) == 0) ? d[15 - k] : !d[15 - k];
      end
      p = ~^d;
      return (h == 38) ? p : !p;
   endfunction

   // {tx_active, bus_a_p, bus_a_n, bus_b_p, bus_b_n, loop_a_p, loop_a_n, loop_b_p, loop_b_n}
   function automatic logic [8:0] exp_lines(input logic [1:0] g, input logic lvl);
      logic [8:0] v;
      v = 9'h100;
      v[7 - 2 * g] = lvl;
      v[6 - 2 * g] = !lvl;
      return v;
   endfunction

   function automatic logic [8:0] got_lines();
      return {tx_active, bus_a_p, bus_a_n, bus_b_p, bus_b_n,
              loop_a_p, loop_a_n, loop_b_p, loop_b_n};
   endfunction

   task automatic pulse_cmd();
      @(negedge clk); cmd_valid = 1'b1;
      @(negedge clk); cmd_valid = 1'b0;
   endtask

   task automatic run_frame(input logic [15:0] d0, input logic s0, input logic [1:0] g0,
                            input bit two, input logic [15:0] d1, input logic s1,
                            input logic [1:0] g1, input bit try_over, input int cmd_at,
                            input int abort_at, input string tag);
      int n;
      int errs;
      logic [8:0] e, g, fe, fg;
      n = two ? 480 : 240;
      errs = 0;
      fe = '0;
      fg = '0;
      @(negedge clk);
      load_valid = 1'b1; load_data = d0; load_sync = s0; load_dest = g0;
      @(negedge clk);
      load_valid = 1'b0;
      @(negedge clk);
      for (int c = 0; c < n + 8; c++) begin
         if (abort_at >= 0 && c >= abort_at) e = '0;
         else if (c < 240) e = exp_lines(g0, exp_level(d0, s0, c));
         else if (c < n)   e = exp_lines(g1, exp_level(d1, s1, c - 240));
         else              e = '0;
         g = got_lines();
         if (g !== e) begin
            if (errs == 0) begin fe = e; fg = g; end
            errs++;
         end
         if (two && c == 25)
            check(load_ready == 1'b0, "R5", "ready while word held", load_ready, 0);
         cmd_valid = (c == cmd_at);
         if (two && c == 20) begin
            load_valid = 1'b1; load_data = d1; load_sync = s1; load_dest = g1;
         end else if (try_over && c == 30) begin
            load_valid = 1'b1; load_data = ~d1;   // must be ignored (R11)
         end else begin
            load_valid = 1'b0;
         end
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      check(errs == 0, tag, "line pattern (first mismatch)", {23'd0, fg}, {23'd0, fe});
   endtask

   initial begin
      logic [15:0] rd;
      logic        rs;
      logic [1:0]  rg;
      int          errs;
      void'($urandom(32'd1553));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(got_lines() == 9'h0, "R1", "lines after reset", got_lines(), 0);
      check(load_ready == 1'b1 && timeout_flag == 1'b0, "R1", "ready/flag after reset",
            {load_ready, timeout_flag}, 2'b10);

      // R4: parity corner words, R2: both sync types
      pulse_cmd();
      run_frame(16'h0000, 1'b1, 2'd0, 0, 0, 0, 0, 0, -1, -1, "R2/R3/R4 zero word");
      pulse_cmd();
      run_frame(16'hFFFF, 1'b0, 2'd1, 0, 0, 0, 0, 0, -1, -1, "R2/R3/R4 all ones");
      pulse_cmd();
      run_frame(16'h0001, 1'b1, 2'd2, 0, 0, 0, 0, 0, -1, -1, "R4/R6 single one, loop A");

      // random words, syncs and destinations (R2 R3 R4 R6 R7)
      for (int i = 0; i < 12; i++) begin
         rd = 16'($urandom);
         rs = 1'($urandom);
         rg = 2'($urandom);
         pulse_cmd();
         run_frame(rd, rs, rg, 0, 0, 0, 0, 0, -1, -1, "R2/R3/R4/R6/R7 random frame");
      end

      // R5 back-to-back, R11 overwrite attempt, R9 clear keeps 480 active clocks alive
      pulse_cmd();
      run_frame(16'h8000, 1'b1, 2'd3, 1, 16'h5A3C, 1'b0, 2'd0, 1, 200, -1,
                "R5/R9/R11 back-to-back");
      check(timeout_flag == 1'b0, "R9", "no timeout after clear", timeout_flag, 0);

      // R8: expiry inside second word, 400 active clocks
      pulse_cmd();
      run_frame(16'hC3A5, 1'b0, 2'd1, 1, 16'h0F0F, 1'b1, 2'd2, 0, -1, 400,
                "R8 cut off at limit");
      check(timeout_flag == 1'b1, "R10", "flag after expiry", timeout_flag, 1);
      check(load_ready == 1'b0, "R10", "ready blocked after expiry", load_ready, 0);

      // R10: loads and command pulses do not restart transmission
      @(negedge clk);
      load_valid = 1'b1; load_data = 16'h1234;
      @(negedge clk);
      load_valid = 1'b0;
      pulse_cmd();
      errs = 0;
      for (int c = 0; c < 300; c++) begin
         if (got_lines() != 9'h0 || timeout_flag != 1'b1) errs++;
         @(negedge clk);
      end
      check(errs == 0, "R10", "idle and sticky while timed out", errs, 0);

      // R1 again after reset, then a working frame
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(timeout_flag == 1'b0 && load_ready == 1'b1, "R1", "reset clears flag",
            {load_ready, timeout_flag}, 2'b10);
      pulse_cmd();
      run_frame(16'hA5A5, 1'b1, 2'd3, 0, 0, 0, 0, 0, -1, -1, "R6/R7 loop B after reset");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule